// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block converts a 64-bit virtual address into a real page address by walking a hierarchy of translation tables in memory. A request carries the virtual address, the access kind (read, write or instruction fetch), a translation-enable flag, a two-bit address-space mode and three space control words. The mode selects which control word is used. That word gives the origin of the top table and a type field, and the type field sets the level where the walk starts: region-first, region-second, region-third or segment. Before the first read, the address is checked against the range that the starting level can cover.

The walker fetches one 8-byte entry per level through a port that has one read outstanding at a time. It checks each entry for validity and for a type code that matches its level, then moves down to the page table. It ends with either a page frame and read/write/execute permissions, or a fault code and an exception word. Requests that bypass translation return the page address unchanged. The block serves one request at a time and signals completion with a single-cycle `done` pulse.

Top module: `xlat_walker`

## Requirements
- R1: The space is chosen at request accept. Mode 0 and mode 1 use `ce_primary`, mode 2 uses `ce_secondary` and mode 3 uses `ce_home`. In mode 2, a fetch (kind 2) uses `ce_primary` instead.
- R2: In a control word, bits 63:12 hold the top table origin and bits 3:2 hold the start type: 3 region-first, 2 region-second, 1 region-third, 0 segment. A clean walk reads one entry per table from the start level down to the page table, so it makes 5, 4, 3 or 2 reads.
- R3: Each entry address is the table origin plus the index times 8. The indexes are address bits 63:53, 52:42, 41:31 and 30:20 for the four upper tables, and bits 19:12 for the page table. Every memory read address is 8-byte aligned.
- R4: A start of region-second with any of bits 63:53 set, region-third with any of bits 63:42 set, or segment with any of bits 63:31 set gives fault code 1. No memory read is made.
- R5: A region or segment entry with bit 5 set gives fault code 2.
- R6: An entry read from a region or segment table must carry that table's own code in bits 3:2 (region-first 3, region-second 2, region-third 1, segment 0), otherwise fault code 1. The bit-5 check takes precedence over this check.
- R7: A page entry with bit 10 set gives fault code 3. A valid page entry with bit 9 set clears write permission.
- R8: A write (kind 1) that ends without write permission gives fault code 4.
- R9: On a fault, `exc_word` is the page address of the request ORed with the space code (primary 0, secondary 2, home 3), plus 4 for fault code 4. On a fault, `real_page` and all permissions are 0. On success, `exc_word` is 0.
- R10: With `xlat_en` low, or with bit 5 of the selected control word set, the result is the page address of the request with read, write and execute all granted, and no memory read is made. The range check of R4 still applies to the control-word case.
- R11: In mode 2, a fetch is granted execute only, and a read or write is granted read and write but not execute.
- R12: `req_ready` is high only when the walker is idle. `done` is high for exactly one cycle. A pending read holds its address until accepted, and a response may arrive any number of cycles later.
- R13: On success, `real_page` is page entry bits 63:12 with bits 11:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| xlat_en | input | 1 | Translation enable |
| asc_mode | input | 2 | Address-space mode |
| ce_primary | input | 64 | Primary space control word |
| ce_secondary | input | 64 | Secondary space control word |
| ce_home | input | 64 | Home space control word |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Table entry |
| done | output | 1 | Result valid for one cycle |
| flt_code | output | 3 | 0 none, 1 specification, 2 segment, 3 page, 4 protection |
| real_page | output | 64 | Real page address |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |
| exc_word | output | 64 | Exception word on fault |

## Verification
The bench builds the walker with its default parameters: 11-bit table indexes, an 8-bit page index and a 12-bit page offset. With these values the address is exactly 64 bits wide, so every index field is reachable, including region-first, whose range has no upper limit. The memory model is a sparse store driven by index slicing written in the bench. Its grant delay and response latency change per scenario, so walks of every depth run under both zero-wait and stalled memory. Fault cases are made by corrupting one stored entry at a chosen level.

// File: rtl/xw_pkg.sv
package xw_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_SPEC  = 3'd1,
    FLT_SEGX  = 3'd2,
    FLT_PAGEX = 3'd3,
    FLT_PROT  = 3'd4
  } flt_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    SP_PRIM = 2'd0,
    SP_ALT  = 2'd1,
    SP_SEC  = 2'd2,
    SP_HOME = 2'd3
  } space_e;

  // walk levels: the table currently being read
  localparam logic [2:0] LV_PAGE = 3'd0;
  localparam logic [2:0] LV_SEG  = 3'd1;
  localparam logic [2:0] LV_R3   = 3'd2;
  localparam logic [2:0] LV_R2   = 3'd3;
  localparam logic [2:0] LV_R1   = 3'd4;

  localparam int CE_REAL_BIT = 5;
  localparam int TE_INV_BIT  = 5;
  localparam int TE_TYPE_LO  = 2;
  localparam int PTE_INV_BIT = 10;
  localparam int PTE_RO_BIT  = 9;
  localparam int PROT_FLAG   = 4;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

endpackage

// File: rtl/xw_index.sv
module xw_index #(
  parameter int IDX_W      = 11,
  parameter int PG_IDX_W   = 8,
  parameter int PAGE_SHIFT = 12,
  localparam int AW        = PAGE_SHIFT + PG_IDX_W + 4 * IDX_W
) (
  input  logic [AW-1:0] vaddr,
  input  logic [2:0]    cur_lvl,
  input  logic [2:0]    start_lvl,
  input  logic [AW-1:0] tbl_origin,
  output logic [AW-1:0] ent_addr,
  output logic          range_bad
);
  import xw_pkg::*;

  localparam int SEG_LO = PAGE_SHIFT + PG_IDX_W;
  localparam int ENT_SH = 3;

  function automatic logic [AW-1:0] entry_at(input logic [AW-1:0] org,
                                             input logic [AW-1:0] idx);
    return org + (idx << ENT_SH);
  endfunction

  logic [AW-1:0] idx_of [5];
  logic [4:0]    above;

  assign idx_of[0] = AW'(vaddr[PAGE_SHIFT +: PG_IDX_W]);
  assign above[0]  = 1'b0;

  for (genvar g = 1; g <= 4; g++) begin : g_lvl
    localparam int LO  = SEG_LO + (g - 1) * IDX_W;
    localparam int LIM = SEG_LO + g * IDX_W;
    assign idx_of[g] = AW'(vaddr[LO +: IDX_W]);
    if (LIM >= AW) begin : g_top
      assign above[g] = 1'b0;
    end else begin : g_cut
      assign above[g] = |vaddr[AW-1:LIM];
    end
  end

  always_comb begin
    case (cur_lvl)
      LV_SEG:  ent_addr = entry_at(tbl_origin, idx_of[1]);
      LV_R3:   ent_addr = entry_at(tbl_origin, idx_of[2]);
      LV_R2:   ent_addr = entry_at(tbl_origin, idx_of[3]);
      LV_R1:   ent_addr = entry_at(tbl_origin, idx_of[4]);
      default: ent_addr = entry_at(tbl_origin, idx_of[0]);
    endcase
  end

  always_comb begin
    case (start_lvl)
      LV_SEG:  range_bad = above[1];
      LV_R3:   range_bad = above[2];
      LV_R2:   range_bad = above[3];
      LV_R1:   range_bad = above[4];
      default: range_bad = 1'b0;
    endcase
  end

endmodule

// File: rtl/xw_entry_chk.sv
module xw_entry_chk #(
  parameter int AW         = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [AW-1:0] entry,
  input  logic [2:0]    cur_lvl,
  output logic [2:0]    flt,
  output logic [AW-1:0] ent_origin,
  output logic          ro
);
  import xw_pkg::*;

  logic [1:0] want_type;
  assign want_type  = 2'(cur_lvl - 3'd1);
  assign ent_origin = {entry[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign ro         = (cur_lvl == LV_PAGE) && entry[PTE_RO_BIT];

  always_comb begin
    flt = FLT_NONE;
    if (cur_lvl == LV_PAGE) begin
      if (entry[PTE_INV_BIT]) flt = FLT_PAGEX;
    end else if (entry[TE_INV_BIT]) begin
      flt = FLT_SEGX;
    end else if (entry[TE_TYPE_LO +: 2] != want_type) begin
      flt = FLT_SPEC;
    end
  end

  // R7
  always_comb begin
    page_flt_kind_chk: assert (cur_lvl != LV_PAGE || flt == FLT_NONE || flt == FLT_PAGEX);
  end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int IDX_W      = 11,
  parameter int PG_IDX_W   = 8,
  parameter int PAGE_SHIFT = 12,
  localparam int AW        = PAGE_SHIFT + PG_IDX_W + 4 * IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic [1:0]    req_kind,
  input  logic          xlat_en,
  input  logic [1:0]    asc_mode,
  input  logic [AW-1:0] ce_primary,
  input  logic [AW-1:0] ce_secondary,
  input  logic [AW-1:0] ce_home,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          done,
  output logic [2:0]    flt_code,
  output logic [AW-1:0] real_page,
  output logic          perm_r,
  output logic          perm_w,
  output logic          perm_x,
  output logic [AW-1:0] exc_word
);
  import xw_pkg::*;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_FIN} st_e;

  function automatic space_e pick_space(input logic [1:0] mode, input logic [1:0] kind);
    case (mode)
      2'd2:    return (kind == ACC_FETCH) ? SP_PRIM : SP_SEC;
      2'd3:    return SP_HOME;
      default: return SP_PRIM;
    endcase
  endfunction

  function automatic perm_t base_perm(input logic [1:0] mode, input logic [1:0] kind);
    if (mode == 2'd2) return (kind == ACC_FETCH) ? 3'b001 : 3'b110;
    return 3'b111;
  endfunction

  function automatic logic [AW-1:0] exc_of(input logic [AW-1:0] page,
                                           input space_e sp, input logic prot);
    return page | AW'(sp) | (prot ? AW'(PROT_FLAG) : '0);
  endfunction

  st_e           st;
  logic [AW-1:0] va_q, origin_q;
  logic [1:0]    kind_q;
  space_e        space_q;
  perm_t         perm_q, res_perm;
  logic [2:0]    lvl_q, res_flt;
  logic [AW-1:0] res_page, res_exc;

  // accept-side selection
  logic [AW-1:0] req_page, ce_sel, ce_origin;
  space_e        sp_sel;
  logic [2:0]    start_lvl;

  assign req_page  = {req_vaddr[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign sp_sel    = pick_space(asc_mode, req_kind);
  assign ce_sel    = (sp_sel == SP_SEC) ? ce_secondary :
                     (sp_sel == SP_HOME) ? ce_home : ce_primary;
  assign ce_origin = {ce_sel[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign start_lvl = {1'b0, ce_sel[TE_TYPE_LO +: 2]} + 3'd1;

  // shared index unit: idle uses the request, walk uses the held state
  logic          idle;
  logic [AW-1:0] ix_va, ix_org, ent_addr;
  logic [2:0]    ix_lvl;
  logic          range_bad;

  assign idle   = (st == S_IDLE);
  assign ix_va  = idle ? req_page  : va_q;
  assign ix_org = idle ? ce_origin : origin_q;
  assign ix_lvl = idle ? start_lvl : lvl_q;

  xw_index #(.IDX_W(IDX_W), .PG_IDX_W(PG_IDX_W), .PAGE_SHIFT(PAGE_SHIFT)) u_index (
    .vaddr      (ix_va),
    .cur_lvl    (ix_lvl),
    .start_lvl  (start_lvl),
    .tbl_origin (ix_org),
    .ent_addr   (ent_addr),
    .range_bad  (range_bad)
  );

  logic [2:0]    chk_flt;
  logic [AW-1:0] chk_origin;
  logic          chk_ro;

  xw_entry_chk #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
    .entry      (mem_rsp_data),
    .cur_lvl    (lvl_q),
    .flt        (chk_flt),
    .ent_origin (chk_origin),
    .ro         (chk_ro)
  );

  // named internal events
  logic  ev_accept, ev_bypass, ev_range_flt, ev_rsp, ev_walk_flt, ev_leaf;
  perm_t leaf_perm;
  logic  wr_denied;

  assign ev_accept    = idle && req_valid;
  assign ev_range_flt = ev_accept && xlat_en && range_bad;
  assign ev_bypass    = ev_accept && (!xlat_en || (!range_bad && ce_sel[CE_REAL_BIT]));
  assign ev_rsp       = (st == S_WAIT) && mem_rsp_valid;
  assign ev_walk_flt  = ev_rsp && (chk_flt != FLT_NONE);
  assign ev_leaf      = ev_rsp && !ev_walk_flt && (lvl_q == LV_PAGE);
  assign leaf_perm    = '{r: perm_q.r, w: perm_q.w & ~chk_ro, x: perm_q.x};
  assign wr_denied    = (kind_q == ACC_WRITE) && !leaf_perm.w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      va_q     <= '0;
      origin_q <= '0;
      kind_q   <= ACC_READ;
      space_q  <= SP_PRIM;
      perm_q   <= '0;
      lvl_q    <= LV_PAGE;
      res_flt  <= FLT_NONE;
      res_page <= '0;
      res_perm <= '0;
      res_exc  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q     <= req_page;
          kind_q   <= req_kind;
          space_q  <= sp_sel;
          perm_q   <= base_perm(asc_mode, req_kind);
          lvl_q    <= start_lvl;
          origin_q <= ce_origin;
          res_flt  <= FLT_NONE;
          res_page <= '0;
          res_perm <= '0;
          res_exc  <= '0;
          if (ev_range_flt) begin
            res_flt <= FLT_SPEC;
            res_exc <= exc_of(req_page, sp_sel, 1'b0);
            st      <= S_FIN;
          end else if (ev_bypass) begin
            res_page <= req_page;
            res_perm <= 3'b111;
            st       <= S_FIN;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: if (mem_rd_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (ev_walk_flt) begin
            res_flt <= chk_flt;
            res_exc <= exc_of(va_q, space_q, 1'b0);
            st      <= S_FIN;
          end else if (ev_leaf) begin
            if (wr_denied) begin
              res_flt <= FLT_PROT;
              res_exc <= exc_of(va_q, space_q, 1'b1);
            end else begin
              res_page <= chk_origin;
              res_perm <= leaf_perm;
            end
            st <= S_FIN;
          end else begin
            lvl_q    <= lvl_q - 3'd1;
            origin_q <= chk_origin;
            st       <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = idle;
  assign mem_rd_valid = (st == S_RD);
  assign mem_rd_addr  = ent_addr;
  assign done         = (st == S_FIN);
  assign flt_code     = res_flt;
  assign real_page    = res_page;
  assign perm_r       = res_perm.r;
  assign perm_w       = res_perm.w;
  assign perm_x       = res_perm.x;
  assign exc_word     = res_exc;

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
  // R3
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[2:0] == 3'b000));
  // R4
  range_flt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_range_flt |=> (done && flt_code == FLT_SPEC && !mem_rd_valid));
  // R8
  write_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flt_code == FLT_NONE && kind_q == ACC_WRITE) |-> perm_w);
  // R9
  clean_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flt_code == FLT_NONE) |-> (exc_word == '0));
  // R9
  fault_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flt_code != FLT_NONE) |-> (!perm_r && !perm_w && !perm_x && real_page == '0));

endmodule

// File: tb/xlat_walker_tb.sv
`timescale 1ns/1ps
module xlat_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        xlat_en = 1'b0;
  logic [1:0]  asc_mode = '0;
  logic [63:0] ce_primary = '0, ce_secondary = '0, ce_home = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done;
  logic [2:0]  flt_code;
  logic [63:0] real_page;
  logic        perm_r, perm_w, perm_x;
  logic [63:0] exc_word;

  always #2 clk = ~clk;

  xlat_walker u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_kind, .xlat_en, .asc_mode,
    .ce_primary, .ce_secondary, .ce_home, .mem_rd_valid, .mem_rd_ready, .mem_rd_addr,
    .mem_rsp_valid, .mem_rsp_data, .done, .flt_code, .real_page, .perm_r, .perm_w,
    .perm_x, .exc_word
  );

  int n_chk = 0, n_bad = 0, n_reads = 0;
  int lat = 0, stall = 0;
  bit finished = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] slot [5];

  logic [2:0]  r_flt;
  logic [63:0] r_page, r_exc;
  logic [2:0]  r_perm;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    logic        busy;
    int          cnt, scnt;
    logic [63:0] paddr;
    busy = 0; cnt = 0; scnt = 0; paddr = '0;
    mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (mem_rd_ready) begin
        mem_rd_ready = 0; busy = 1; cnt = lat; n_reads++;
      end else if (busy) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data  = mem.exists(paddr) ? mem[paddr] : 64'h0;
          busy = 0;
        end else cnt--;
      end else if (mem_rd_valid) begin
        if (scnt >= stall) begin
          mem_rd_ready = 1; paddr = mem_rd_addr; scnt = 0;
          chk("R3", "read alignment", {61'h0, paddr[2:0]}, 64'h0);
        end else scnt++;
      end
    end
  end

  function automatic logic [63:0] ix(input logic [63:0] va, input int lv);
    case (lv)
      4:       return {53'h0, va[63:53]};
      3:       return {53'h0, va[52:42]};
      2:       return {53'h0, va[41:31]};
      1:       return {53'h0, va[30:20]};
      default: return {56'h0, va[19:12]};
    endcase
  endfunction

  // builds tables from root down; table at level lv holds type code lv-1
  task automatic map(input logic [63:0] va, input logic [63:0] root, input int top,
                     input logic [63:0] base, input logic [63:0] pte);
    logic [63:0] org, nxt;
    org = root;
    for (int lv = top; lv >= 1; lv--) begin
      nxt = base + 64'(lv) * 64'h20000;
      slot[lv] = org + (ix(va, lv) << 3);
      mem[slot[lv]] = nxt | (64'(lv - 1) << 2);
      org = nxt;
    end
    slot[0] = org + (ix(va, 0) << 3);
    mem[slot[0]] = pte;
  endtask

  function automatic logic [63:0] ce(input logic [63:0] root, input int typ, input bit real_sp);
    return root | (64'(typ) << 2) | (real_sp ? 64'h20 : 64'h0);
  endfunction

  task automatic xlat(input logic [63:0] va, input logic [1:0] kind, input logic en,
                      input logic [1:0] mode, input int exp_reads);
    int  waitc;
    bit  rdy_busy;
    @(negedge clk);
    req_vaddr = va; req_kind = kind; xlat_en = en; asc_mode = mode;
    req_valid = 1; n_reads = 0;
    @(negedge clk);
    req_valid = 0;
    waitc = 0; rdy_busy = 0;
    while (!done && waitc < 2000) begin
      if (req_ready) rdy_busy = 1;
      @(negedge clk);
      waitc++;
    end
    if (req_ready) rdy_busy = 1;
    chk("R12", "done seen", {63'h0, done}, 64'h1);
    chk("R12", "ready low while busy", {63'h0, rdy_busy}, 64'h0);
    r_flt = flt_code; r_page = real_page; r_exc = exc_word;
    r_perm = {perm_r, perm_w, perm_x};
    @(negedge clk);
    chk("R12", "done one cycle", {63'h0, done}, 64'h0);
    chk("R2", "read count", 64'(n_reads), 64'(exp_reads));
  endtask

  task automatic expect_ok(input string rq, input logic [63:0] page, input logic [2:0] perm);
    chk(rq, "fault code", {61'h0, r_flt}, 64'h0);
    chk("R13", "real page", r_page, page);
    chk(rq, "perms", {61'h0, r_perm}, {61'h0, perm});
    chk("R9", "exc word clear", r_exc, 64'h0);
  endtask

  task automatic expect_flt(input string rq, input logic [2:0] code, input logic [63:0] exc);
    chk(rq, "fault code", {61'h0, r_flt}, {61'h0, code});
    chk("R9", "exc word", r_exc, exc);
    chk("R9", "page on fault", r_page, 64'h0);
    chk("R9", "perms on fault", {61'h0, r_perm}, 64'h0);
  endtask

  task automatic t_reset();
    chk("R12", "ready after reset", {63'h0, req_ready}, 64'h1);
    chk("R12", "done after reset", {63'h0, done}, 64'h0);
    chk("R12", "rd valid after reset", {63'h0, mem_rd_valid}, 64'h0);
  endtask

  task automatic t_off();  // R10
    mem.delete();
    xlat(64'h1234_5678_9abc_def0, 2'd1, 1'b0, 2'd2, 0);
    expect_ok("R10", 64'h1234_5678_9abc_d000, 3'b111);
  endtask

  task automatic t_region1();  // R1 R2 R3 R13
    logic [63:0] va = 64'hABCD_E123_4567_8FFF;
    mem.delete(); lat = 3; stall = 1;
    ce_primary = ce(64'h10_0000, 3, 0);
    map(va, 64'h10_0000, 4, 64'h100_0000, 64'h7770_0000);
    xlat(va, 2'd0, 1'b1, 2'd0, 5);
    expect_ok("R2", 64'h7770_0000, 3'b111);
    xlat(va, 2'd0, 1'b1, 2'd1, 5);   // mode 1 behaves as primary
    expect_ok("R1", 64'h7770_0000, 3'b111);
  endtask

  task automatic t_region3_home();  // R1 R2
    logic [63:0] va = 64'h0000_0123_4567_8000;
    mem.delete(); lat = 0; stall = 0;
    ce_primary = ce(64'h30_0000, 0, 0);
    ce_home    = ce(64'h20_0000, 1, 0);
    map(va, 64'h20_0000, 2, 64'h200_0000, 64'h5555_5000);
    xlat(va, 2'd1, 1'b1, 2'd3, 3);
    expect_ok("R1", 64'h5555_5000, 3'b111);
  endtask

  task automatic t_segment_ro();  // R7 R8 R9
    logic [63:0] va = 64'h0000_0000_7654_3000;
    mem.delete(); lat = 2; stall = 2;
    ce_primary = ce(64'h40_0000, 0, 0);
    map(va, 64'h40_0000, 1, 64'h300_0000, 64'h9000 | 64'h200);
    xlat(va, 2'd0, 1'b1, 2'd0, 2);
    expect_ok("R7", 64'h9000, 3'b101);
    xlat(va, 2'd1, 1'b1, 2'd0, 2);
    expect_flt("R8", 3'd4, 64'h7654_3004);
  endtask

  task automatic t_range();  // R4 R10
    mem.delete(); lat = 1; stall = 0;
    ce_secondary = ce(64'h50_0000, 2, 0);
    xlat(64'h1000_0000_0000_0000, 2'd0, 1'b1, 2'd2, 0);
    expect_flt("R4", 3'd1, 64'h1000_0000_0000_0002);
    ce_primary = ce(64'h50_0000, 0, 0);
    xlat(64'h0000_0000_8000_0000, 2'd0, 1'b1, 2'd0, 0);
    expect_flt("R4", 3'd1, 64'h0000_0000_8000_0000);
    ce_home = ce(64'h50_0000, 1, 1);  // real space still range checked
    xlat(64'h0000_0400_0000_0000, 2'd0, 1'b1, 2'd3, 0);
    expect_flt("R4", 3'd1, 64'h0000_0400_0000_0003);
  endtask

  task automatic t_invalid();  // R5
    logic [63:0] va = 64'h0012_3456_789A_B000;
    mem.delete(); lat = 1; stall = 1;
    ce_secondary = ce(64'h60_0000, 2, 0);
    map(va, 64'h60_0000, 3, 64'h400_0000, 64'h8_8000);
    mem[slot[3]] = mem[slot[3]] | 64'h20;
    xlat(va, 2'd0, 1'b1, 2'd2, 1);
    expect_flt("R5", 3'd2, 64'h0012_3456_789A_B002);
    map(va, 64'h60_0000, 3, 64'h400_0000, 64'h8_8000);
    mem[slot[1]] = mem[slot[1]] | 64'h20;
    xlat(va, 2'd0, 1'b1, 2'd2, 3);
    expect_flt("R5", 3'd2, 64'h0012_3456_789A_B002);
  endtask

  task automatic t_type();  // R6
    logic [63:0] va = 64'hF00F_0F0F_1234_5000;
    mem.delete(); lat = 0; stall = 0;
    ce_primary = ce(64'h70_0000, 3, 0);
    map(va, 64'h70_0000, 4, 64'h500_0000, 64'h1000);
    mem[slot[2]] = (mem[slot[2]] & ~64'hC) | 64'hC;
    xlat(va, 2'd0, 1'b1, 2'd0, 3);
    expect_flt("R6", 3'd1, 64'hF00F_0F0F_1234_5000);
    mem[slot[2]] = mem[slot[2]] | 64'h20;   // invalid takes precedence
    xlat(va, 2'd0, 1'b1, 2'd0, 3);
    expect_flt("R6", 3'd2, 64'hF00F_0F0F_1234_5000);
  endtask

  task automatic t_page_invalid();  // R7
    logic [63:0] va = 64'h0000_0000_1111_2000;
    mem.delete(); lat = 4; stall = 0;
    ce_secondary = ce(64'h80_0000, 0, 0);
    map(va, 64'h80_0000, 1, 64'h600_0000, 64'h3000 | 64'h400);
    xlat(va, 2'd1, 1'b1, 2'd2, 2);
    expect_flt("R7", 3'd3, 64'h0000_0000_1111_2002);
  endtask

  task automatic t_real();  // R10
    mem.delete();
    ce_primary = ce(64'h90_0000, 1, 1);
    xlat(64'h0000_0012_3456_7ABC, 2'd1, 1'b1, 2'd0, 0);
    expect_ok("R10", 64'h0000_0012_3456_7000, 3'b111);
  endtask

  task automatic t_secondary();  // R1 R11
    logic [63:0] va = 64'h0000_0000_2345_6000;
    mem.delete(); lat = 1; stall = 1;
    ce_primary   = ce(64'hA0_0000, 0, 0);
    ce_secondary = ce(64'hB0_0000, 0, 0);
    ce_home      = ce(64'hC0_0000, 0, 0);
    map(va, 64'hA0_0000, 1, 64'h700_0000, 64'hAAA000);
    map(va, 64'hB0_0000, 1, 64'h800_0000, 64'hBBB000);
    map(va, 64'hC0_0000, 1, 64'h900_0000, 64'hCCC000);
    xlat(va, 2'd2, 1'b1, 2'd2, 2);
    expect_ok("R11", 64'hAAA000, 3'b001);
    xlat(va, 2'd0, 1'b1, 2'd2, 2);
    expect_ok("R11", 64'hBBB000, 3'b110);
    xlat(va, 2'd1, 1'b1, 2'd2, 2);
    expect_ok("R11", 64'hBBB000, 3'b110);
    xlat(va, 2'd2, 1'b1, 2'd3, 2);
    expect_ok("R1", 64'hCCC000, 3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_off();
    t_region1();
    t_region3_home();
    t_segment_ro();
    t_range();
    t_invalid();
    t_type();
    t_page_invalid();
    t_real();
    t_secondary();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule